// File: doc/BRIEF.md
# Per-Thread Performance Counter Unit

This block holds the event counters for one multithreaded core. Each hardware thread owns a fixed pair of counters. The instruction counter advances once for every instruction that thread retires. The event counter advances on one event line that software picks, for example a second-level cache data load miss or a translation miss. Both counters of a thread are gated by a privilege filter, so software can count user work only, supervisor work only, or both. The core has no counter of its own.

Software reaches the counters through a flat register window. Each thread has a configuration word and two counter words. Writing a counter loads it with a start value. A counter that wraps past its maximum sets a sticky flag in its thread's configuration word.

For utilization reporting, an interval sampler sums the retirements of all threads over a programmable number of cycles. At the end of each interval it publishes that sum next to the cycle count. The core retires at most one instruction per cycle, so the published sum is a direct fraction of the core's peak rate.

Top module: `perf_ctr_unit`

## Requirements
- R1: While reset is low, every configuration word, every counter, `sample_vld_o`, `core_instr_o` and `core_cycles_o` reads zero.
- R2: The instruction counter of thread t increments by one on each cycle with `retire_i[t]` high, when the thread's privilege filter passes.
- R3: The event counter of thread t increments on each cycle where `event_i[t*NUM_EVT + sel]` is high and the filter passes. Here sel is configuration bits [3:0]. A sel value of NUM_EVT or above (8 to 15 by default) counts nothing.
- R4: The privilege filter works as follows. Configuration bit 4 enables counting while `priv_i[t]` is 0 (user). Configuration bit 5 enables counting while `priv_i[t]` is 1 (supervisor). The filter gates both counters of the thread.
- R5: The register address is {thread, slot}. The thread number is in `reg_addr_i[3:2]` and the slot is in `reg_addr_i[1:0]`. Slot 0 is the configuration word, zero-extended, with its flags in bits [7:0]. Slot 1 is the event counter and slot 2 is the instruction counter. Slot 3 reads zero and ignores writes. `reg_rdata_o` is combinational. A write takes effect at the clock edge.
- R6: A write to a counter in the same cycle as an increment of that counter loads the written value, and the increment is lost.
- R7: A counter that increments from all ones wraps to zero. The wrap sets configuration bit 6 for the event counter and bit 7 for the instruction counter. These flags hold until a configuration write loads them. That write wins over a wrap in the same cycle.
- R8: With `ivl_len_i` = N > 0, an interval closes every N cycles. One cycle after it closes, `sample_vld_o` pulses for one cycle. At that point `core_instr_o` holds the number of cycles in the interval with any `retire_i` bit high (unfiltered), and `core_cycles_o` holds N. The accumulation then restarts from zero.
- R9: With `ivl_len_i` = 0, the sampler is held cleared and `sample_vld_o` stays low.
- R10: At most one `retire_i` bit is high per cycle. A published `core_instr_o` never exceeds `core_cycles_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | NUM_THREADS | Per-thread instruction retired this cycle |
| priv_i | input | NUM_THREADS | Per-thread privilege, 1 = supervisor |
| event_i | input | NUM_THREADS*NUM_EVT | Event lines, NUM_EVT per thread |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address {thread, slot} |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data |
| ivl_len_i | input | IVL_W | Sampling interval length in cycles, 0 = off |
| sample_vld_o | output | 1 | One-cycle pulse when a sample is published |
| core_instr_o | output | IVL_W | Retirements summed over the last interval |
| core_cycles_o | output | IVL_W | Cycle length of the last interval |

## Verification
The bench targets four corner cases:

- **Counter wrap.** It seeds an instruction counter two below its limit. A design that saturates instead of wrapping, or that fails to latch the overflow flag, leaves the wrong value or flag bit behind.
- **Write versus increment.** It collides a counter write with a live event in the same cycle. A design that lets the increment win reads back one above the written value.
- **Unused select codes and the privilege filter.** It drives all event lines high while the selector holds an unused code. It also retires supervisor instructions while only user counting is enabled. A design with a loose decode or filter counts where it must not.
- **Interval closure.** It checks the sampler at full retirement rate and with a zero interval. An off-by-one close shows up as a sum or cycle count that differs from the programmed length.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int SEL_W = 4;
  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    SLOT_CFG = 2'd0,
    SLOT_EVT = 2'd1,
    SLOT_INS = 2'd2,
    SLOT_RSV = 2'd3
  } slot_e;

  typedef struct packed {
    logic             ovf_ins;
    logic             ovf_evt;
    logic             sup_en;
    logic             usr_en;
    logic [SEL_W-1:0] sel;
  } cfg_t;
endpackage

// File: rtl/perf_ctr.sv
module perf_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] q_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] q_q;

  assign wrap_o = inc_i & ~we_i & (&q_q);
  assign q_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (we_i)  q_q <= wdata_i;
    else if (inc_i) q_q <= q_q + CNT_W'(1);
  end

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(wdata_i)); // R6
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !we_i) |=> q_o == $past(q_o) + CNT_W'(1)); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !we_i) |=> $stable(q_o)); // R3
endmodule

// File: rtl/perf_thread.sv
module perf_thread
  import perf_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 8  // at most 2**SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               retire_i,
  input  logic               priv_i,
  input  logic [NUM_EVT-1:0] event_i,
  input  logic               cfg_we_i,
  input  logic               evt_we_i,
  input  logic               ins_we_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output cfg_t               cfg_o,
  output logic [CNT_W-1:0]   evt_o,
  output logic [CNT_W-1:0]   ins_o
);
  cfg_t cfg_q;
  logic mode_ok, ev_hit, evt_inc, ins_inc, evt_wrap, ins_wrap;

  assign mode_ok = priv_i ? cfg_q.sup_en : cfg_q.usr_en;

  always_comb begin
    ev_hit = 1'b0;
    for (int e = 0; e < NUM_EVT; e++)
      if (cfg_q.sel == SEL_W'(e)) ev_hit = event_i[e];
  end

  assign evt_inc = ev_hit & mode_ok;
  assign ins_inc = retire_i & mode_ok;

  perf_ctr #(.CNT_W(CNT_W)) u_evt (
    .clk_i, .rst_ni, .inc_i(evt_inc), .we_i(evt_we_i), .wdata_i,
    .q_o(evt_o), .wrap_o(evt_wrap)
  );

  perf_ctr #(.CNT_W(CNT_W)) u_ins (
    .clk_i, .rst_ni, .inc_i(ins_inc), .we_i(ins_we_i), .wdata_i,
    .q_o(ins_o), .wrap_o(ins_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_t'(wdata_i[CFG_W-1:0]);
    else begin
      if (evt_wrap) cfg_q.ovf_evt <= 1'b1;
      if (ins_wrap) cfg_q.ovf_ins <= 1'b1;
    end
  end

  assign cfg_o = cfg_q;

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.ovf_evt && !cfg_we_i) |=> cfg_q.ovf_evt); // R7
  AST_WRAP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_inc && !ins_we_i && !cfg_we_i && (&ins_o)) |=> (ins_o == '0 && cfg_q.ovf_ins)); // R7
  AST_UNUSED_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cfg_q.sel) >= NUM_EVT && !evt_we_i) |=> $stable(evt_o)); // R3
  AST_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i && !cfg_q.sup_en && !ins_we_i) |=> $stable(ins_o)); // R4
endmodule

// File: rtl/perf_ivl_sampler.sv
module perf_ivl_sampler #(
  parameter int NUM_THREADS = 4,
  parameter int IVL_W       = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] retire_i,
  input  logic [IVL_W-1:0]       ivl_len_i,
  output logic                   vld_o,
  output logic [IVL_W-1:0]       instr_o,
  output logic [IVL_W-1:0]       cycles_o
);
  logic [IVL_W-1:0] cyc_q, acc_q;
  logic             any_ret, ivl_end;

  assign any_ret = |retire_i;
  assign ivl_end = (ivl_len_i != '0) && (cyc_q >= ivl_len_i - IVL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0; acc_q <= '0; vld_o <= 1'b0; instr_o <= '0; cycles_o <= '0;
    end else if (ivl_len_i == '0) begin
      cyc_q <= '0; acc_q <= '0; vld_o <= 1'b0;
    end else if (ivl_end) begin
      instr_o  <= acc_q + IVL_W'(any_ret);
      cycles_o <= cyc_q + IVL_W'(1);
      vld_o    <= 1'b1;
      cyc_q    <= '0;
      acc_q    <= '0;
    end else begin
      cyc_q <= cyc_q + IVL_W'(1);
      acc_q <= acc_q + IVL_W'(any_ret);
      vld_o <= 1'b0;
    end
  end

  AST_ONE_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(retire_i)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> instr_o <= cycles_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ivl_len_i == '0) |=> !vld_o); // R9
  AST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && ivl_len_i > IVL_W'(1) && $stable(ivl_len_i)) |=> !vld_o); // R8
endmodule

// File: rtl/perf_ctr_unit.sv
module perf_ctr_unit
  import perf_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 32,
  parameter int NUM_EVT     = 8,
  parameter int IVL_W       = 24,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int ADDR_W     = TID_W + 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_THREADS-1:0]         retire_i,
  input  logic [NUM_THREADS-1:0]         priv_i,
  input  logic [NUM_THREADS*NUM_EVT-1:0] event_i,
  input  logic                           reg_we_i,
  input  logic [ADDR_W-1:0]              reg_addr_i,
  input  logic [CNT_W-1:0]               reg_wdata_i,
  output logic [CNT_W-1:0]               reg_rdata_o,
  input  logic [IVL_W-1:0]               ivl_len_i,
  output logic                           sample_vld_o,
  output logic [IVL_W-1:0]               core_instr_o,
  output logic [IVL_W-1:0]               core_cycles_o
);
  logic [TID_W-1:0] tid;
  slot_e            slot;
  cfg_t             cfg_a [NUM_THREADS];
  logic [CNT_W-1:0] evt_a [NUM_THREADS];
  logic [CNT_W-1:0] ins_a [NUM_THREADS];

  assign tid  = reg_addr_i[ADDR_W-1:2];
  assign slot = slot_e'(reg_addr_i[1:0]);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic sel_t;
    assign sel_t = reg_we_i && (tid == TID_W'(t));
    perf_thread #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_thr (
      .clk_i, .rst_ni,
      .retire_i (retire_i[t]),
      .priv_i   (priv_i[t]),
      .event_i  (event_i[t*NUM_EVT +: NUM_EVT]),
      .cfg_we_i (sel_t && slot == SLOT_CFG),
      .evt_we_i (sel_t && slot == SLOT_EVT),
      .ins_we_i (sel_t && slot == SLOT_INS),
      .wdata_i  (reg_wdata_i),
      .cfg_o    (cfg_a[t]),
      .evt_o    (evt_a[t]),
      .ins_o    (ins_a[t])
    );
  end

  always_comb begin
    unique case (slot)
      SLOT_CFG: reg_rdata_o = {{(CNT_W-CFG_W){1'b0}}, cfg_a[tid]};
      SLOT_EVT: reg_rdata_o = evt_a[tid];
      SLOT_INS: reg_rdata_o = ins_a[tid];
      default:  reg_rdata_o = '0;
    endcase
  end

  perf_ivl_sampler #(.NUM_THREADS(NUM_THREADS), .IVL_W(IVL_W)) u_smp (
    .clk_i, .rst_ni, .retire_i, .ivl_len_i,
    .vld_o(sample_vld_o), .instr_o(core_instr_o), .cycles_o(core_cycles_o)
  );

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot == SLOT_RSV) |-> reg_rdata_o == '0); // R5
endmodule

// File: tb/perf_ctr_unit_tb_top.sv
module perf_ctr_unit_tb_top;
  localparam int NT = 4, CW = 32, NE = 8, IW = 24;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0] retire = '0, priv = '0;
  logic [NT*NE-1:0] evt = '0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0, rdata;
  logic [IW-1:0] ivl_len = '0, c_instr, c_cyc;
  logic          s_vld;

  perf_ctr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .priv_i(priv), .event_i(evt),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .ivl_len_i(ivl_len), .sample_vld_o(s_vld),
    .core_instr_o(c_instr), .core_cycles_o(c_cyc)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  logic [7:0]    m_cfg [NT];
  logic [CW-1:0] m_c0 [NT], m_c1 [NT];
  logic          m_vld;
  logic [IW-1:0] m_instr, m_cycles, m_cnt, m_acc;

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] m_read(logic [3:0] a);
    case (a[1:0])
      2'd0: return {24'd0, m_cfg[a[3:2]]};
      2'd1: return m_c0[a[3:2]];
      2'd2: return m_c1[a[3:2]];
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] s);
    case (s)
      2'd0: return "R7 cfg/ovf";
      2'd1: return "R3 event ctr";
      2'd2: return "R2 instr ctr";
      default: return "R5 reserved slot";
    endcase
  endfunction

  task automatic model_step();
    for (int t = 0; t < NT; t++) begin
      logic [7:0] cf; logic en, ev, i0, i1, wc, w0, w1;
      cf = m_cfg[t];
      en = priv[t] ? cf[5] : cf[4];
      ev = (cf[3:0] < NE) ? evt[t*NE + cf[3:0]] : 1'b0;
      i0 = ev & en;
      i1 = retire[t] & en;
      wc = reg_we && (reg_addr[3:2] == t[1:0]);
      w0 = i0 && !(wc && reg_addr[1:0] == 2'd1) && (&m_c0[t]);
      w1 = i1 && !(wc && reg_addr[1:0] == 2'd2) && (&m_c1[t]);
      if (wc && reg_addr[1:0] == 2'd1) m_c0[t] = reg_wdata;
      else if (i0) m_c0[t] = m_c0[t] + 1;
      if (wc && reg_addr[1:0] == 2'd2) m_c1[t] = reg_wdata;
      else if (i1) m_c1[t] = m_c1[t] + 1;
      if (wc && reg_addr[1:0] == 2'd0) m_cfg[t] = reg_wdata[7:0];
      else begin
        if (w0) m_cfg[t][6] = 1'b1;
        if (w1) m_cfg[t][7] = 1'b1;
      end
    end
    if (ivl_len == 0) begin
      m_cnt = 0; m_acc = 0; m_vld = 0;
    end else if (m_cnt >= ivl_len - 1) begin
      m_instr = m_acc + IW'(|retire); m_cycles = m_cnt + 1; m_vld = 1;
      m_cnt = 0; m_acc = 0;
    end else begin
      m_cnt = m_cnt + 1; m_acc = m_acc + IW'(|retire); m_vld = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin m_cfg[t] = 0; m_c0[t] = 0; m_c1[t] = 0; end
      m_vld = 0; m_instr = 0; m_cycles = 0; m_cnt = 0; m_acc = 0;
    end else model_step();
  end

  // sampler outputs compared every cycle against the model (R8, R9, R10)
  always @(negedge clk) if (rst_n) begin
    chk("R8 sample_vld", CW'(s_vld), CW'(m_vld));
    if (m_vld) begin
      chk("R8 core_instr", CW'(c_instr), CW'(m_instr));
      chk("R8 core_cycles", CW'(c_cyc), CW'(m_cycles));
      n_chk++;
      if (c_instr > c_cyc) begin
        n_fail++;
        $display("FAIL R10 instr=%0d exceeds cycles=%0d", c_instr, c_cyc);
      end
    end
    if (ivl_len == 0 && $past(ivl_len) == 0) chk("R9 idle sampler", CW'(s_vld), '0);
  end

  task automatic wr(logic [3:0] a, logic [CW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_exp(logic [3:0] a, logic [CW-1:0] exp, string req);
    reg_addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic check_all();
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      reg_addr = 4'(a); #1;
      chk(tag_of(reg_addr[1:0]), rdata, m_read(reg_addr));
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    cycles(3);
    for (int a = 0; a < 16; a++) begin
      reg_addr = 4'(a); #1;
      chk("R1 reset reg", rdata, '0);
    end
    chk("R1 reset sample", {7'd0, s_vld, c_instr}, '0);
    chk("R1 reset cycles", CW'(c_cyc), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4: event select 2, user only, events while user
    wr(4'h0, 32'h12);
    evt[2] = 1'b1; priv[0] = 1'b0;
    cycles(3);
    evt[2] = 1'b0;
    rd_exp(4'h1, 32'd3, "R3 selected event count");
    // R4: supervisor retirements filtered out
    priv[0] = 1'b1; retire[0] = 1'b1;
    cycles(3);
    retire[0] = 1'b0; priv[0] = 1'b0;
    rd_exp(4'h2, 32'd0, "R4 supervisor filtered");
    // R2: user retirements counted
    retire[0] = 1'b1; cycles(2); retire[0] = 1'b0;
    rd_exp(4'h2, 32'd2, "R2 user retire count");

    // R3: unused select code counts nothing
    wr(4'h4, 32'h3C);
    evt = '1; cycles(4); evt = '0;
    rd_exp(4'h5, 32'd0, "R3 unused select");

    // R7: wrap and sticky overflow on thread 2 instruction counter
    wr(4'hA, 32'hFFFF_FFFE);
    wr(4'h8, 32'h30);
    retire[2] = 1'b1; cycles(2); retire[2] = 1'b0;
    rd_exp(4'hA, 32'd0, "R7 wrap to zero");
    rd_exp(4'h8, 32'hB0, "R7 overflow flag set");
    retire[2] = 1'b1; cycles(3); retire[2] = 1'b0;
    rd_exp(4'h8, 32'hB0, "R7 overflow sticky");
    wr(4'h8, 32'h30);
    rd_exp(4'h8, 32'h30, "R7 cfg write clears");

    // R6: write beats increment
    wr(4'hC, 32'h30);
    evt[3*NE] = 1'b1;
    wr(4'hD, 32'h55);
    evt[3*NE] = 1'b0;
    rd_exp(4'hD, 32'h55, "R6 write wins");

    // R5: reserved slot write ignored
    wr(4'h3, 32'hFFFF_FFFF);
    rd_exp(4'h3, 32'd0, "R5 reserved reads zero");
    rd_exp(4'h0, 32'h12, "R5 reserved write no effect");
    check_all();

    // R8: full-rate interval of 5
    ivl_len = 24'd5;
    for (int i = 0; i < 23; i++) begin
      retire = NT'(1) << (i % NT);
      @(negedge clk);
      if (s_vld) begin
        chk("R8 full-rate instr", CW'(c_instr), 32'd5);
        chk("R8 full-rate cycles", CW'(c_cyc), 32'd5);
      end
    end
    retire = '0;
    // R9: disabled sampler
    ivl_len = '0;
    cycles(12);

    // random phase
    ivl_len = 24'(3 + $urandom_range(0, 20));
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = $urandom_range(0, NT);
      retire = (k == NT || $urandom_range(0, 3) == 0) ? '0 : NT'(1) << k;
      priv   = NT'($urandom);
      evt    = $urandom;
      reg_we = ($urandom_range(0, 7) == 0);
      reg_addr  = 4'($urandom);
      reg_wdata = (reg_addr[1:0] == 2'd0) ? CW'($urandom_range(0, 255))
                : ($urandom_range(0, 3) == 0 ? 32'hFFFF_FFF0 + CW'($urandom_range(0, 15)) : $urandom);
      if (i == 2000) ivl_len = 24'(1 + $urandom_range(0, 6));
      @(negedge clk);
      if (i % 250 == 249) begin
        reg_we = 1'b0;
        check_all();
      end
    end
    reg_we = 1'b0; retire = '0; evt = '0;
    check_all();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule